// File: doc/BRIEF.md
# Strobed Handshake Port Channel

This block is one 8-bit port channel with a handshake to a peripheral. A mode write selects one of two directions. In input direction, the peripheral pulls a strobe low to load its data into an input latch. The channel then raises an input-buffer-full flag until the host reads the port. In output direction, a host write loads an output latch that drives the pins. An active-low output-buffer-full flag tells the peripheral that new data is waiting, and it stays asserted until the peripheral pulls its acknowledge low.

In both directions the channel raises an interrupt request when a transfer completes. The request reaches the interrupt output only while a per-channel interrupt-enable flip-flop is set. The host sets or clears that flip-flop with a single-bit set/reset command that names a port C bit position. The channel also produces the bits it contributes to the port C status word. In that word, the enable flag takes the place of the strobe or acknowledge pin level. A parameter selects channel A or channel B bit placement.

The peripheral strobes, the host strobes and their data pass through two-flop synchronisers. Edges are detected on the synchronised copies.

Top module: `hsk_port`

## Requirements
- R1: While reset is asserted and after its release, ibf_o is 0, obf_no is 1, intr_o is 0, the enable flag is 0, the direction is input (pin_oe_o 0) and both latches hold 0.
- R2: In input direction (mode_dir_i 0 at the mode write), while the synchronised strobe is low, the synchronised pin data is loaded into the input latch, which host_rdata_o shows, and ibf_o is set to 1.
- R3: ibf_o clears on a rising edge of the synchronised host read strobe. A low strobe in the same cycle wins and keeps ibf_o at 1.
- R4: In input direction, the interrupt request sets on a rising edge of the strobe when ibf_o is 1 and the host read strobe is high. It clears on a falling edge of the host read strobe, and the clear wins.
- R5: In output direction (mode_dir_i 1), a rising edge of the host write strobe loads host_wdata_i into the output latch and drives obf_no to 0. The latch is driven on pin_data_o with pin_oe_o at 1 and shown on host_rdata_o.
- R6: obf_no returns to 1 in any cycle where the synchronised acknowledge is low, unless a host write rising edge occurs in that cycle.
- R7: In output direction, the interrupt request sets on a rising edge of acknowledge when obf_no is 1 and the host write strobe is high. It clears on a falling edge of the host write strobe, and the clear wins.
- R8: intr_o is the interrupt request ANDed with the enable flag. A request held while the flag is 0 appears as soon as the flag is set.
- R9: A set/reset command (bsr_wr_i, with bit index bsr_bit_i[2:0]) loads bsr_val_i into the enable flag only when the index equals the channel's enable position. That position is 4 in input direction and 6 in output direction for channel A, and 2 in both directions for channel B. Any other index leaves the flag unchanged.
- R10: A mode write captures mode_dir_i as the new direction. It clears the enable flag, ibf_o, the request and both latches, sets obf_no to 1, and overrides a set/reset command in the same cycle.
- R11: The status bits are pc_stat_o, and pc_own_o marks the positions the channel drives; all other bits are 0. Channel A in input direction drives [3] intr, [4] enable and [5] ibf. Channel A in output direction drives [3] intr, [6] enable and [7] obf_n. Channel B drives [0] intr, [1] ibf (input) or obf_n (output), and [2] enable.
- R12: A change on a strobe, acknowledge or host strobe input first affects the flags after the third rising clock edge following it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_wr_i | input | 1 | Mode write pulse |
| mode_dir_i | input | 1 | Direction for a mode write, 1 = output |
| bsr_wr_i | input | 1 | Bit set/reset command pulse |
| bsr_bit_i | input | 3 | Port C bit index of the command |
| bsr_val_i | input | 1 | Value written by the command |
| host_rd_ni | input | 1 | Host read strobe for this port, active low |
| host_wr_ni | input | 1 | Host write strobe for this port, active low |
| host_wdata_i | input | DW | Host write data |
| host_rdata_o | output | DW | Port data seen by the host |
| pin_data_i | input | DW | Peripheral data in |
| pin_data_o | output | DW | Output latch to the pins |
| pin_oe_o | output | 1 | Pin output enable (output direction) |
| stb_ni | input | 1 | Peripheral strobe, active low |
| ack_ni | input | 1 | Peripheral acknowledge, active low |
| ibf_o | output | 1 | Input buffer full |
| obf_no | output | 1 | Output buffer full, active low |
| intr_o | output | 1 | Interrupt request |
| pc_stat_o | output | 8 | Port C status bits of this channel |
| pc_own_o | output | 8 | Port C positions driven by this channel |

## Verification
The properties assume that mode writes and set/reset commands are single-cycle pulses in the clock domain. They predict nothing about when a synchronised strobe lands, only what the flags and status look like afterwards. The stimulus drives every input half a cycle away from the sampling edge. Host write data is held for several cycles after the write strobe rises, and pin data stays steady while the strobe is low. The random phase changes strobes and data at arbitrary cycles, and a behavioural model delays them through the same three-edge window, so synchroniser slips do not cause false mismatches.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
  typedef enum logic {DIR_IN = 1'b0, DIR_OUT = 1'b1} dir_e;

  // port C bit holding the enable flag for a channel / direction
  function automatic logic [2:0] inte_bit(input bit chan_a, input dir_e d);
    if (!chan_a) return 3'd2;
    return (d == DIR_OUT) ? 3'd6 : 3'd4;
  endfunction
endpackage

// File: rtl/hsk_sync.sv
module hsk_sync #(
  parameter int          W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/hsk_flags.sv
module hsk_flags
  import hsk_pkg::*;
#(
  parameter bit CHAN_A = 1'b1,
  parameter int DW     = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_wr_i,
  input  dir_e          mode_dir_i,
  input  logic          bsr_wr_i,
  input  logic [2:0]    bsr_bit_i,
  input  logic          bsr_val_i,
  input  logic          stb_s_i,
  input  logic          ack_s_i,
  input  logic          rd_s_i,
  input  logic          wr_s_i,
  input  logic [DW-1:0] din_s_i,
  input  logic [DW-1:0] wdata_s_i,
  output dir_e          dir_o,
  output logic          inte_o,
  output logic          ibf_o,
  output logic          obf_no,
  output logic          req_o,
  output logic [DW-1:0] in_lat_o,
  output logic [DW-1:0] out_lat_o
);
  logic stb_p, ack_p, rd_p, wr_p;
  dir_e dir_q;
  logic inte_q, ibf_q, obf_nq, req_q;
  logic [DW-1:0] in_lat_q, out_lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {stb_p, ack_p, rd_p, wr_p} <= 4'b1111;
    end else begin
      {stb_p, ack_p, rd_p, wr_p} <= {stb_s_i, ack_s_i, rd_s_i, wr_s_i};
    end
  end

  logic stb_rise, ack_rise, rd_rise, rd_fall, wr_rise, wr_fall, bsr_hit;
  assign stb_rise = !stb_p &&  stb_s_i;
  assign ack_rise = !ack_p &&  ack_s_i;
  assign rd_rise  = !rd_p  &&  rd_s_i;
  assign rd_fall  =  rd_p  && !rd_s_i;
  assign wr_rise  = !wr_p  &&  wr_s_i;
  assign wr_fall  =  wr_p  && !wr_s_i;
  assign bsr_hit  = bsr_wr_i && (bsr_bit_i == inte_bit(CHAN_A, dir_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q     <= DIR_IN;
      inte_q    <= 1'b0;
      ibf_q     <= 1'b0;
      obf_nq    <= 1'b1;
      req_q     <= 1'b0;
      in_lat_q  <= '0;
      out_lat_q <= '0;
    end else if (mode_wr_i) begin
      dir_q     <= mode_dir_i;
      inte_q    <= 1'b0;
      ibf_q     <= 1'b0;
      obf_nq    <= 1'b1;
      req_q     <= 1'b0;
      in_lat_q  <= '0;
      out_lat_q <= '0;
    end else begin
      if (bsr_hit) inte_q <= bsr_val_i;
      if (dir_q == DIR_IN) begin
        if (!stb_s_i) begin
          in_lat_q <= din_s_i;
          ibf_q    <= 1'b1;
        end else if (rd_rise) begin
          ibf_q    <= 1'b0;
        end
        if (rd_fall)                           req_q <= 1'b0;
        else if (stb_rise && ibf_q && rd_s_i)  req_q <= 1'b1;
      end else begin
        if (wr_rise) begin
          out_lat_q <= wdata_s_i;
          obf_nq    <= 1'b0;
        end else if (!ack_s_i) begin
          obf_nq    <= 1'b1;
        end
        if (wr_fall)                           req_q <= 1'b0;
        else if (ack_rise && obf_nq && wr_s_i) req_q <= 1'b1;
      end
    end
  end

  assign dir_o     = dir_q;
  assign inte_o    = inte_q;
  assign ibf_o     = ibf_q;
  assign obf_no    = obf_nq;
  assign req_o     = req_q;
  assign in_lat_o  = in_lat_q;
  assign out_lat_o = out_lat_q;
endmodule

// File: rtl/hsk_status.sv
module hsk_status
  import hsk_pkg::*;
#(
  parameter bit CHAN_A = 1'b1
) (
  input  dir_e       dir_i,
  input  logic       intr_i,
  input  logic       inte_i,
  input  logic       ibf_i,
  input  logic       obf_ni,
  output logic [7:0] stat_o,
  output logic [7:0] own_o
);
  generate
    if (CHAN_A) begin : g_chan_a
      always_comb begin
        stat_o    = '0;
        stat_o[3] = intr_i;
        if (dir_i == DIR_IN) begin
          stat_o[4] = inte_i;
          stat_o[5] = ibf_i;
          own_o     = 8'b0011_1000;
        end else begin
          stat_o[6] = inte_i;
          stat_o[7] = obf_ni;
          own_o     = 8'b1100_1000;
        end
      end
    end else begin : g_chan_b
      always_comb begin
        stat_o    = '0;
        stat_o[0] = intr_i;
        stat_o[1] = (dir_i == DIR_IN) ? ibf_i : obf_ni;
        stat_o[2] = inte_i;
        own_o     = 8'b0000_0111;
      end
    end
  endgenerate
endmodule

// File: rtl/hsk_port.sv
module hsk_port
  import hsk_pkg::*;
#(
  parameter bit CHAN_A = 1'b1,
  parameter int DW     = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_wr_i,
  input  logic          mode_dir_i,
  input  logic          bsr_wr_i,
  input  logic [2:0]    bsr_bit_i,
  input  logic          bsr_val_i,
  input  logic          host_rd_ni,
  input  logic          host_wr_ni,
  input  logic [DW-1:0] host_wdata_i,
  output logic [DW-1:0] host_rdata_o,
  input  logic [DW-1:0] pin_data_i,
  output logic [DW-1:0] pin_data_o,
  output logic          pin_oe_o,
  input  logic          stb_ni,
  input  logic          ack_ni,
  output logic          ibf_o,
  output logic          obf_no,
  output logic          intr_o,
  output logic [7:0]    pc_stat_o,
  output logic [7:0]    pc_own_o
);
  localparam int SW = 2 * DW + 4;
  localparam logic [SW-1:0] SYNC_RST = {{(2 * DW){1'b0}}, 4'b1111};

  logic [SW-1:0] sync_d, sync_q;
  assign sync_d = {pin_data_i, host_wdata_i, stb_ni, ack_ni, host_rd_ni, host_wr_ni};

  hsk_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sync_d),
    .q_o   (sync_q)
  );

  dir_e          dir;
  logic          inte, req;
  logic [DW-1:0] in_lat, out_lat;

  hsk_flags #(.CHAN_A(CHAN_A), .DW(DW)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_wr_i (mode_wr_i),
    .mode_dir_i(dir_e'(mode_dir_i)),
    .bsr_wr_i  (bsr_wr_i),
    .bsr_bit_i (bsr_bit_i),
    .bsr_val_i (bsr_val_i),
    .stb_s_i   (sync_q[3]),
    .ack_s_i   (sync_q[2]),
    .rd_s_i    (sync_q[1]),
    .wr_s_i    (sync_q[0]),
    .din_s_i   (sync_q[SW-1 -: DW]),
    .wdata_s_i (sync_q[4 +: DW]),
    .dir_o     (dir),
    .inte_o    (inte),
    .ibf_o     (ibf_o),
    .obf_no    (obf_no),
    .req_o     (req),
    .in_lat_o  (in_lat),
    .out_lat_o (out_lat)
  );

  assign intr_o       = req & inte;
  assign pin_oe_o     = (dir == DIR_OUT);
  assign pin_data_o   = out_lat;
  assign host_rdata_o = (dir == DIR_OUT) ? out_lat : in_lat;

  hsk_status #(.CHAN_A(CHAN_A)) u_status (
    .dir_i (dir),
    .intr_i(intr_o),
    .inte_i(inte),
    .ibf_i (ibf_o),
    .obf_ni(obf_no),
    .stat_o(pc_stat_o),
    .own_o (pc_own_o)
  );
endmodule

// File: rtl/hsk_port_chk.sv
module hsk_port_chk #(
  parameter bit CHAN_A = 1'b1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mode_wr_i,
  input logic       bsr_wr_i,
  input logic [2:0] bsr_bit_i,
  input logic       bsr_val_i,
  input logic       pin_oe_o,
  input logic       ibf_o,
  input logic       obf_no,
  input logic       intr_o,
  input logic [7:0] pc_stat_o,
  input logic [7:0] pc_own_o
);
  logic [2:0] en_pos;
  assign en_pos = CHAN_A ? (pin_oe_o ? 3'd6 : 3'd4) : 3'd2;

  AST_IBF_INPUT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ibf_o |-> !pin_oe_o); // R2
  AST_OBF_OUTPUT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !obf_no |-> pin_oe_o); // R5
  AST_INTR_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_o |-> pc_stat_o[en_pos]); // R8
  AST_BSR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bsr_wr_i && !mode_wr_i && bsr_bit_i == en_pos) |=> pc_stat_o[$past(en_pos)] == $past(bsr_val_i)); // R9
  AST_MODE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i |=> (!intr_o && !ibf_o && obf_no && !pc_stat_o[en_pos])); // R10
  AST_OWN_THREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(pc_own_o) == 3) && ((pc_stat_o & ~pc_own_o) == 8'h00)); // R11
endmodule

bind hsk_port hsk_port_chk #(.CHAN_A(CHAN_A)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_wr_i(mode_wr_i),
  .bsr_wr_i (bsr_wr_i),
  .bsr_bit_i(bsr_bit_i),
  .bsr_val_i(bsr_val_i),
  .pin_oe_o (pin_oe_o),
  .ibf_o    (ibf_o),
  .obf_no   (obf_no),
  .intr_o   (intr_o),
  .pc_stat_o(pc_stat_o),
  .pc_own_o (pc_own_o)
);

// File: tb/hsk_port_test.sv
`timescale 1ns/1ps
module hsk_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       mode_wr = 0, mode_dir = 0, bsr_wr = 0, bsr_val = 0;
  logic [2:0] bsr_bit = 0;
  logic       rd_n = 1, wr_n = 1, stb_n = 1, ack_n = 1;
  logic [7:0] wdata = 0, din = 0;

  logic [7:0] rdata [2], pdo [2], stat [2], own [2];
  logic       oe [2], ibf [2], obf_n [2], intr [2];

  hsk_port #(.CHAN_A(1'b1), .DW(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_wr_i(mode_wr), .mode_dir_i(mode_dir),
    .bsr_wr_i(bsr_wr), .bsr_bit_i(bsr_bit), .bsr_val_i(bsr_val),
    .host_rd_ni(rd_n), .host_wr_ni(wr_n), .host_wdata_i(wdata), .host_rdata_o(rdata[0]),
    .pin_data_i(din), .pin_data_o(pdo[0]), .pin_oe_o(oe[0]), .stb_ni(stb_n), .ack_ni(ack_n),
    .ibf_o(ibf[0]), .obf_no(obf_n[0]), .intr_o(intr[0]), .pc_stat_o(stat[0]), .pc_own_o(own[0]));

  hsk_port #(.CHAN_A(1'b0), .DW(8)) uut_b (
    .clk_i(clk), .rst_ni(rst_n), .mode_wr_i(mode_wr), .mode_dir_i(mode_dir),
    .bsr_wr_i(bsr_wr), .bsr_bit_i(bsr_bit), .bsr_val_i(bsr_val),
    .host_rd_ni(rd_n), .host_wr_ni(wr_n), .host_wdata_i(wdata), .host_rdata_o(rdata[1]),
    .pin_data_i(din), .pin_data_o(pdo[1]), .pin_oe_o(oe[1]), .stb_ni(stb_n), .ack_ni(ack_n),
    .ibf_o(ibf[1]), .obf_no(obf_n[1]), .intr_o(intr[1]), .pc_stat_o(stat[1]), .pc_own_o(own[1]));

  int vectors = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  typedef struct packed {logic [7:0] din, wd; logic stb, ack, rd, wr;} smp_t;
  smp_t hist[$];
  logic       m_dir [2], m_inte [2], m_ibf [2], m_obfn [2], m_req [2];
  logic [7:0] m_in [2], m_out [2];

  function automatic smp_t idle_smp();
    smp_t t; t.din = 0; t.wd = 0; t.stb = 1; t.ack = 1; t.rd = 1; t.wr = 1; return t;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {};
      for (int i = 0; i < 3; i++) hist.push_back(idle_smp());
      for (int k = 0; k < 2; k++) begin
        m_dir[k] = 0; m_inte[k] = 0; m_ibf[k] = 0; m_obfn[k] = 1; m_req[k] = 0;
        m_in[k] = 0; m_out[k] = 0;
      end
    end else begin
      smp_t s, p, c;
      s = hist[1]; p = hist[2];
      c.din = din; c.wd = wdata; c.stb = stb_n; c.ack = ack_n; c.rd = rd_n; c.wr = wr_n;
      for (int k = 0; k < 2; k++) begin
        int pos;
        logic old;
        pos = (k == 0) ? (m_dir[k] ? 6 : 4) : 2;
        if (mode_wr) begin
          m_dir[k] = mode_dir; m_inte[k] = 0; m_ibf[k] = 0; m_obfn[k] = 1; m_req[k] = 0;
          m_in[k] = 0; m_out[k] = 0;
        end else begin
          if (bsr_wr && int'(bsr_bit) == pos) m_inte[k] = bsr_val;
          if (!m_dir[k]) begin
            old = m_ibf[k];
            if (!s.stb) begin m_in[k] = s.din; m_ibf[k] = 1; end
            else if (!p.rd && s.rd) m_ibf[k] = 0;
            if (p.rd && !s.rd) m_req[k] = 0;
            else if (!p.stb && s.stb && old && s.rd) m_req[k] = 1;
          end else begin
            old = m_obfn[k];
            if (!p.wr && s.wr) begin m_out[k] = s.wd; m_obfn[k] = 0; end
            else if (!s.ack) m_obfn[k] = 1;
            if (p.wr && !s.wr) m_req[k] = 0;
            else if (!p.ack && s.ack && old && s.wr) m_req[k] = 1;
          end
        end
      end
      hist.push_front(c);
      void'(hist.pop_back());
    end
  end

  function automatic logic [7:0] exp_stat(int k);
    logic [7:0] v = 0;
    logic ir = m_req[k] & m_inte[k];
    if (k == 0) begin
      v[3] = ir;
      if (!m_dir[k]) begin v[4] = m_inte[k]; v[5] = m_ibf[k]; end
      else begin v[6] = m_inte[k]; v[7] = m_obfn[k]; end
    end else begin
      v[0] = ir; v[1] = m_dir[k] ? m_obfn[k] : m_ibf[k]; v[2] = m_inte[k];
    end
    return v;
  endfunction

  function automatic logic [7:0] exp_own(int k);
    if (k == 1) return 8'h07;
    return m_dir[k] ? 8'hC8 : 8'h38;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int k = 0; k < 2; k++) begin
        chk("R2/R3", "ibf", ibf[k], m_ibf[k]);
        chk("R5/R6", "obf_n", obf_n[k], m_obfn[k]);
        chk("R4/R7/R8", "intr", intr[k], m_req[k] & m_inte[k]);
        chk("R2/R5", "rdata", rdata[k], m_dir[k] ? m_out[k] : m_in[k]);
        chk("R5", "pin_data", pdo[k], m_out[k]);
        chk("R10", "pin_oe", oe[k], m_dir[k]);
        chk("R11", "pc_stat", stat[k], exp_stat(k));
        chk("R11", "pc_own", own[k], exp_own(k));
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic set_mode(input logic d);
    @(negedge clk); mode_wr = 1; mode_dir = d;
    @(negedge clk); mode_wr = 0;
  endtask
  task automatic bsr(input logic [2:0] b, input logic v);
    @(negedge clk); bsr_wr = 1; bsr_bit = b; bsr_val = v;
    @(negedge clk); bsr_wr = 0;
  endtask
  task automatic strobe(input logic [7:0] d);
    @(negedge clk); din = d; stb_n = 0;
    cyc(3); stb_n = 1; cyc(4);
  endtask
  task automatic host_read();
    @(negedge clk); rd_n = 0; cyc(4); rd_n = 1; cyc(4);
  endtask
  task automatic host_write(input logic [7:0] d);
    @(negedge clk); wdata = d; wr_n = 0; cyc(4); wr_n = 1; cyc(5);
  endtask
  task automatic ack_pulse();
    @(negedge clk); ack_n = 0; cyc(3); ack_n = 1; cyc(4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state held during reset
    chk("R1", "ibf_rst", ibf[0], 0);
    chk("R1", "obf_n_rst", obf_n[0], 1);
    chk("R1", "intr_rst", intr[0], 0);
    chk("R1", "oe_rst", oe[0], 0);
    chk("R1", "stat_rst", stat[0], 8'h00);
    chk("R1", "rdata_rst", rdata[0], 8'h00);
    rst_n = 1;
    cyc(3);

    // input direction
    set_mode(0);
    bsr(3'd7, 1);                                  // R9: foreign index
    cyc(1);
    chk("R9", "inte_ignored", stat[0][4], 0);
    bsr(3'd4, 1); bsr(3'd2, 1);
    // R12: latency of strobe to ibf
    @(negedge clk); din = 8'hA5; stb_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); chk("R12", "ibf_before", ibf[0], 0);
    @(posedge clk);
    @(negedge clk); chk("R12", "ibf_after", ibf[0], 1);
    chk("R2", "in_latch", rdata[0], 8'hA5);
    cyc(2); stb_n = 1; cyc(5);
    chk("R4", "intr_in", intr[0], 1);
    host_read();
    chk("R3", "ibf_clr", ibf[0], 0);
    chk("R4", "intr_clr", intr[0], 0);
    // request held while disabled, then enabled
    bsr(3'd4, 0); bsr(3'd2, 0);
    strobe(8'h3C);
    chk("R8", "intr_masked", intr[0], 0);
    bsr(3'd4, 1);
    cyc(1);
    chk("R8", "intr_unmasked", intr[0], 1);
    host_read();
    // strobe overlapping a read
    @(negedge clk); rd_n = 0; cyc(2); din = 8'h5A; stb_n = 0; cyc(2); rd_n = 1; cyc(2); stb_n = 1; cyc(6);
    chk("R3", "ibf_strobe_wins", ibf[0], 1);
    host_read();

    // output direction
    set_mode(1);
    cyc(1);
    chk("R10", "mode_clear_inte", stat[0][6], 0);
    chk("R10", "mode_dir", oe[0], 1);
    bsr(3'd4, 1);
    cyc(1);
    chk("R9", "inte_wrong_pos", stat[0][6], 0);
    bsr(3'd6, 1); bsr(3'd2, 1);
    host_write(8'hC3);
    chk("R5", "obf_low", obf_n[0], 0);
    chk("R5", "pins", pdo[0], 8'hC3);
    ack_pulse();
    chk("R6", "obf_high", obf_n[0], 1);
    chk("R7", "intr_out", intr[0], 1);
    host_write(8'h81);
    chk("R7", "intr_out_clr", intr[0], 0);
    // write while ack held low
    @(negedge clk); ack_n = 0; cyc(2); wdata = 8'h42; wr_n = 0; cyc(3); wr_n = 1; cyc(6); ack_n = 1; cyc(5);
    chk("R6", "obf_after_ack_low", obf_n[0], 1);
    set_mode(0);
    cyc(1);
    chk("R10", "mode_clear_intr", intr[0], 0);
    chk("R10", "mode_clear_latch", rdata[0], 8'h00);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      mode_wr = ($urandom_range(0, 199) == 0);
      mode_dir = $urandom_range(0, 1);
      bsr_wr = ($urandom_range(0, 15) == 0);
      bsr_bit = $urandom_range(0, 7);
      bsr_val = $urandom_range(0, 3) != 0;
      if ($urandom_range(0, 5) == 0) stb_n = ~stb_n;
      if ($urandom_range(0, 5) == 0) ack_n = ~ack_n;
      if ($urandom_range(0, 6) == 0) rd_n = ~rd_n;
      if ($urandom_range(0, 6) == 0) wr_n = ~wr_n;
      if ($urandom_range(0, 3) == 0) din = 8'($urandom);
      if ($urandom_range(0, 3) == 0) wdata = 8'($urandom);
    end
    @(negedge clk); mode_wr = 0; bsr_wr = 0;
    cyc(5);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule